// File: doc/BRIEF.md
# Branch Fault Retry Policy Controller

This block owns the enable of a single protected load branch. It watches an overcurrent comparator and an over-temperature flag. It decides when to open the branch switch, how long to let it cool, and whether and when to close it again. Three policies are selectable at run time:

- **Latch-off:** the first trip holds the branch off until software or a supervisor issues a clear.
- **Hiccup:** the controller restarts forever on a fixed cooldown plus growing backoff rhythm.
- **Budgeted retry:** only a limited number of automatic restarts are allowed before the branch is latched off.

Overcurrent must persist for a qualification window before it counts as a trip, so short current spikes do not open the switch. Over-temperature bypasses that window. The wait after each failed restart grows geometrically up to a ceiling. A sustained fault-free run on the branch rearms the restart budget. A one-cycle log strobe marks every trip and every escalation to the latched state, so a downstream recorder can timestamp the first trip, each failed restart and the final lockout.

Top module: `brk_guard`

## Requirements
- R1: After reset the switch gate is on, the fault and latched flags are low, the retry count is 0 and the log strobe is low.
- R2: Overcurrent trips the branch only when it is high on FAULT_QUAL consecutive clock edges; if it drops earlier the controller returns to normal operation with the gate still on.
- R3: Over-temperature while the branch is on trips it at the very next clock edge, with no qualification window.
- R4: A trip turns the gate off and raises the fault flag. It then holds a cooldown of COOL_CYC cycles, waits the current backoff interval, and re-enables the gate for one transition cycle before normal operation resumes.
- R5: The retry count rises by one each time a backoff wait begins. In budgeted mode (mode 2'b10 or 2'b11), a cooldown that ends with the count already at RETRY_MAX escalates to the latched state.
- R6: The first backoff lasts BO_BASE cycles; each later backoff doubles the previous one, capped at BO_MAX. A clear or a good-run rearm restores BO_BASE.
- R7: In the latched state the gate stays off and the latched flag high whatever overcurrent does. Only the clear input leaves it, which also zeroes the retry count. The clear input has no effect in any other state.
- R8: In latch-off mode (mode 2'b00), the cycle after the trip cycle enters the latched state with no cooldown or retry.
- R9: In hiccup mode (mode 2'b01), restarts continue indefinitely and the latched state is never entered; the retry count saturates at its all-ones value.
- R10: The log strobe is high for exactly the cycle in which the trip state is entered and the cycle in which the latched state is entered.
- R11: After GOOD_RUN consecutive clock edges in normal operation with neither fault input high, the retry count returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_i | input | 1 | Overcurrent comparator output |
| ot_i | input | 1 | Over-temperature indication |
| clr_i | input | 1 | Clear / re-enable command for the latched state |
| mode_i | input | 2 | Policy: 00 latch-off, 01 hiccup, 10/11 budgeted retry |
| gate_o | output | 1 | Branch switch enable |
| fault_o | output | 1 | Branch is off because of a fault |
| latched_o | output | 1 | Branch is latched off and needs a clear |
| retry_cnt_o | output | $clog2(RETRY_MAX+1) | Automatic restarts since the last rearm |
| log_o | output | 1 | One-cycle strobe per trip or latch escalation |

## Verification
The assertions guard the per-edge transition rules on every cycle:
- over-temperature trips at once;
- a dropped overcurrent returns to normal operation;
- the latched state holds without a clear;
- latch-off mode escalates straight after the trip;
- hiccup mode never escalates from cooldown;
- the trip cycle carries the log strobe;
- timers count down one per cycle;
- the backoff stays within its limits;
- the retry count moves only by single steps or to zero.

Exact durations can only be shown by the bench scenarios, which run a full budget to exhaustion and a clear:
- the cooldown and the doubling, capped backoff lengths;
- the count at which the budget runs out;
- the good-run rearm;
- that a clear outside the latched state does nothing.

// File: rtl/brk_pkg.sv
package brk_pkg;

   typedef enum logic [2:0] {
      ST_ON    = 3'd0,
      ST_DET   = 3'd1,
      ST_TRIP  = 3'd2,
      ST_COOL  = 3'd3,
      ST_WAIT  = 3'd4,
      ST_LATCH = 3'd5,
      ST_REEN  = 3'd6
   } brk_state_e;

   localparam logic [1:0] MODE_LATCHOFF = 2'b00;
   localparam logic [1:0] MODE_HICCUP   = 2'b01;

   function automatic int unsigned brk_max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/brk_tmr.sv
module brk_tmr #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [TW-1:0] ld_val,
   output logic          done
);

   logic [TW-1:0] t_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= '0;
      end else if (ld) begin
         t_q <= ld_val;
      end else if (t_q != '0) begin
         t_q <= t_q - 1'b1;
      end
   end

   assign done = (t_q == '0);

   // R4: an idle running timer decrements by exactly one per cycle
   a_r4_tmr_step : assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && t_q != '0) |=> (t_q == $past(t_q) - 1'b1));

endmodule

// File: rtl/brk_backoff.sv
module brk_backoff #(
   parameter int unsigned BW        = 8,
   parameter int unsigned BO_BASE   = 4,
   parameter int unsigned BO_MAX    = 64,
   parameter bit          BO_DOUBLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          rearm,
   output logic [BW-1:0] bo_o
);

   localparam logic [BW-1:0] BASE_V = BW'(BO_BASE);
   localparam logic [BW:0]   MAX_W  = (BW+1)'(BO_MAX);

   logic [BW-1:0] bo_q;
   logic [BW-1:0] bo_nxt;

   generate
      if (BO_DOUBLE) begin : g_double
         logic [BW:0] dbl;
         always_comb begin
            dbl    = {bo_q, 1'b0};
            bo_nxt = (dbl > MAX_W) ? MAX_W[BW-1:0] : dbl[BW-1:0];
         end
      end else begin : g_fixed
         assign bo_nxt = bo_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bo_q <= BASE_V;
      end else if (rearm) begin
         bo_q <= BASE_V;
      end else if (step) begin
         bo_q <= bo_nxt;
      end
   end

   assign bo_o = bo_q;

   // R6: backoff stays inside its configured band
   a_r6_bo_band : assert property (@(posedge clk) disable iff (!rst_n)
      (bo_q >= BASE_V) && ({1'b0, bo_q} <= MAX_W));

   // R6: a rearm restores the base interval
   a_r6_bo_rearm : assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> (bo_q == BASE_V));

endmodule

// File: rtl/brk_budget.sv
module brk_budget #(
   parameter int unsigned CW        = 2,
   parameter int unsigned RETRY_MAX = 3,
   parameter int unsigned GOOD_RUN  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          clr,
   input  logic          good,
   output logic [CW-1:0] cnt_o,
   output logic          limit_o,
   output logic          rearm_o
);

   localparam int unsigned GW = (GOOD_RUN > 2) ? $clog2(GOOD_RUN) : 1;
   localparam logic [GW-1:0] G_LAST = GW'(GOOD_RUN - 1);
   localparam logic [CW-1:0] C_LIM  = CW'(RETRY_MAX);
   localparam logic [CW-1:0] C_SAT  = {CW{1'b1}};

   logic [CW-1:0] cnt_q;
   logic [GW-1:0] g_q;
   logic          term;

   assign term = good && (g_q == G_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         g_q   <= '0;
      end else begin
         if (clr || term) begin
            cnt_q <= '0;
         end else if (inc && cnt_q != C_SAT) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (!good || term) begin
            g_q <= '0;
         end else begin
            g_q <= g_q + 1'b1;
         end
      end
   end

   assign cnt_o   = cnt_q;
   assign limit_o = (cnt_q >= C_LIM);
   assign rearm_o = clr || term;

   // R11: the end of a good run empties the count
   a_r11_goodrun_clears : assert property (@(posedge clk) disable iff (!rst_n)
      term |=> (cnt_q == '0));

   // R5: a backoff start adds exactly one unless saturated or cleared
   a_r5_inc_by_one : assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !term && cnt_q != C_SAT) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/brk_guard.sv
module brk_guard
   import brk_pkg::*;
#(
   parameter int unsigned FAULT_QUAL = 16,
   parameter int unsigned COOL_CYC   = 200,
   parameter int unsigned BO_BASE    = 50,
   parameter int unsigned BO_MAX     = 800,
   parameter bit          BO_DOUBLE  = 1'b1,
   parameter int unsigned GOOD_RUN   = 1000,
   parameter int unsigned RETRY_MAX  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           oc_i,
   input  logic                           ot_i,
   input  logic                           clr_i,
   input  logic [1:0]                     mode_i,
   output logic                           gate_o,
   output logic                           fault_o,
   output logic                           latched_o,
   output logic [$clog2(RETRY_MAX+1)-1:0] retry_cnt_o,
   output logic                           log_o
);

   localparam int unsigned CW   = $clog2(RETRY_MAX + 1);
   localparam int unsigned BW   = $clog2(BO_MAX + 1);
   localparam int unsigned MAXV = brk_max3(FAULT_QUAL, COOL_CYC, BO_MAX);
   localparam int unsigned TW   = $clog2(MAXV + 1);

   localparam logic [TW-1:0] QUAL_LD = TW'(FAULT_QUAL - 2);
   localparam logic [TW-1:0] COOL_LD = TW'(COOL_CYC - 1);

   generate
      if (FAULT_QUAL < 2 || COOL_CYC < 1 || BO_BASE < 1 || BO_MAX < BO_BASE ||
          GOOD_RUN < 2 || RETRY_MAX < 1) begin : g_param_err
         $error("brk_guard: parameter set out of range");
      end
   endgenerate

   brk_state_e    st_q, st_d;
   logic          tmr_ld;
   logic [TW-1:0] tmr_val;
   logic          tmr_done;
   logic          bo_step;
   logic [BW-1:0] bo_cur;
   logic          bud_inc;
   logic          bud_clr;
   logic          bud_limit;
   logic          bud_rearm;
   logic          good_cyc;
   logic [CW-1:0] cnt;
   logic          log_q;
   logic          hiccup;

   assign hiccup   = (mode_i == MODE_HICCUP);
   assign good_cyc = (st_q == ST_ON) && !oc_i && !ot_i;

   brk_tmr #(.TW(TW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (tmr_ld),
      .ld_val (tmr_val),
      .done   (tmr_done)
   );

   brk_backoff #(
      .BW        (BW),
      .BO_BASE   (BO_BASE),
      .BO_MAX    (BO_MAX),
      .BO_DOUBLE (BO_DOUBLE)
   ) u_backoff (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (bo_step),
      .rearm (bud_rearm),
      .bo_o  (bo_cur)
   );

   brk_budget #(
      .CW        (CW),
      .RETRY_MAX (RETRY_MAX),
      .GOOD_RUN  (GOOD_RUN)
   ) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (bud_inc),
      .clr     (bud_clr),
      .good    (good_cyc),
      .cnt_o   (cnt),
      .limit_o (bud_limit),
      .rearm_o (bud_rearm)
   );

   always_comb begin
      st_d    = st_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      bo_step = 1'b0;
      bud_inc = 1'b0;
      bud_clr = 1'b0;
      unique case (st_q)
         ST_ON: begin
            if (ot_i) begin
               st_d = ST_TRIP;
            end else if (oc_i) begin
               st_d    = ST_DET;
               tmr_ld  = 1'b1;
               tmr_val = QUAL_LD;
            end
         end
         ST_DET: begin
            if (ot_i) begin
               st_d = ST_TRIP;
            end else if (!oc_i) begin
               st_d = ST_ON;
            end else if (tmr_done) begin
               st_d = ST_TRIP;
            end
         end
         ST_TRIP: begin
            if (mode_i == MODE_LATCHOFF) begin
               st_d = ST_LATCH;
            end else begin
               st_d    = ST_COOL;
               tmr_ld  = 1'b1;
               tmr_val = COOL_LD;
            end
         end
         ST_COOL: begin
            if (tmr_done) begin
               if (!hiccup && bud_limit) begin
                  st_d = ST_LATCH;
               end else begin
                  st_d    = ST_WAIT;
                  tmr_ld  = 1'b1;
                  tmr_val = TW'(bo_cur) - 1'b1;
                  bo_step = 1'b1;
                  bud_inc = 1'b1;
               end
            end
         end
         ST_WAIT: begin
            if (tmr_done) begin
               st_d = ST_REEN;
            end
         end
         ST_LATCH: begin
            if (clr_i) begin
               st_d    = ST_REEN;
               bud_clr = 1'b1;
            end
         end
         ST_REEN: begin
            st_d = ST_ON;
         end
         default: begin
            st_d = ST_LATCH;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_ON;
         log_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         log_q <= ((st_d == ST_TRIP)  && (st_q != ST_TRIP)) ||
                  ((st_d == ST_LATCH) && (st_q != ST_LATCH));
      end
   end

   assign gate_o      = (st_q == ST_ON) || (st_q == ST_DET) || (st_q == ST_REEN);
   assign fault_o     = (st_q == ST_TRIP) || (st_q == ST_COOL) ||
                        (st_q == ST_WAIT) || (st_q == ST_LATCH);
   assign latched_o   = (st_q == ST_LATCH);
   assign retry_cnt_o = cnt;
   assign log_o       = log_q;

   // R3: over-temperature while conducting trips on the next edge
   a_r3_ot_immediate : assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_ON || st_q == ST_DET) && ot_i) |=> (st_q == ST_TRIP));

   // R2: overcurrent dropping during qualification returns to normal operation
   a_r2_glitch_return : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DET && !oc_i && !ot_i) |=> (st_q == ST_ON));

   // R7: the latched state holds until a clear arrives
   a_r7_latch_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LATCH && !clr_i) |=> (st_q == ST_LATCH));

   // R8: latch-off mode escalates straight from the trip
   a_r8_latchoff_direct : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRIP && mode_i == MODE_LATCHOFF) |=> (st_q == ST_LATCH));

   // R9: hiccup mode never escalates out of cooldown
   a_r9_hiccup_no_latch : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_COOL && hiccup) |=> (st_q != ST_LATCH));

   // R10: every trip cycle carries the log strobe
   a_r10_trip_logged : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRIP) |-> log_o);

endmodule

// File: tb/test_brk_guard.sv
module test_brk_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oc = 1'b0;
   logic       ot = 1'b0;
   logic       clr = 1'b0;
   logic [1:0] mode = 2'b10;
   logic       gate, fault, latched, logp;
   logic [1:0] cnt;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   brk_guard #(
      .FAULT_QUAL (3),
      .COOL_CYC   (2),
      .BO_BASE    (2),
      .BO_MAX     (3),
      .BO_DOUBLE  (1'b1),
      .GOOD_RUN   (4),
      .RETRY_MAX  (2)
   ) i_brk_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .oc_i        (oc),
      .ot_i        (ot),
      .clr_i       (clr),
      .mode_i      (mode),
      .gate_o      (gate),
      .fault_o     (fault),
      .latched_o   (latched),
      .retry_cnt_o (cnt),
      .log_o       (logp)
   );

   // row: req[14:11] oc ot clr[10:8] mode[7:6] gate fault latched[5:3] cnt[2:1] log[0]
   localparam int NROW = 50;
   localparam logic [14:0] TBL [NROW] = '{
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd0, 1'b0},  // R2 qualify 1
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd0, 1'b0},  // R2 qualify 2
      {4'd10, 3'b100, 2'b10, 3'b010, 2'd0, 1'b1},  // R10 first trip logged
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd0, 1'b0},  // R4 cooldown
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd0, 1'b0},  // R4 cooldown
      {4'd5,  3'b000, 2'b10, 3'b010, 2'd1, 1'b0},  // R5 backoff start counts
      {4'd7,  3'b001, 2'b10, 3'b010, 2'd1, 1'b0},  // R7 clear ignored in backoff
      {4'd4,  3'b000, 2'b10, 3'b100, 2'd1, 1'b0},  // R4 re-enable after base wait
      {4'd4,  3'b100, 2'b10, 3'b100, 2'd1, 1'b0},  // R4 back in normal operation
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd1, 1'b0},
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd1, 1'b0},
      {4'd10, 3'b100, 2'b10, 3'b010, 2'd1, 1'b1},  // R10 failed retry logged
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd1, 1'b0},
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd1, 1'b0},
      {4'd5,  3'b000, 2'b10, 3'b010, 2'd2, 1'b0},  // R5 second retry
      {4'd6,  3'b000, 2'b10, 3'b010, 2'd2, 1'b0},  // R6 longer wait
      {4'd6,  3'b000, 2'b10, 3'b010, 2'd2, 1'b0},  // R6 capped at 3 cycles
      {4'd6,  3'b000, 2'b10, 3'b100, 2'd2, 1'b0},  // R6 re-enable after 3
      {4'd4,  3'b100, 2'b10, 3'b100, 2'd2, 1'b0},
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd2, 1'b0},
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd2, 1'b0},
      {4'd10, 3'b100, 2'b10, 3'b010, 2'd2, 1'b1},
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd2, 1'b0},
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd2, 1'b0},
      {4'd5,  3'b000, 2'b10, 3'b011, 2'd2, 1'b1},  // R5 budget spent, R10 latch logged
      {4'd7,  3'b000, 2'b10, 3'b011, 2'd2, 1'b0},  // R7 latched holds
      {4'd7,  3'b100, 2'b10, 3'b011, 2'd2, 1'b0},  // R7 overcurrent has no effect
      {4'd7,  3'b001, 2'b10, 3'b100, 2'd0, 1'b0},  // R7 clear re-enables, count zero
      {4'd7,  3'b000, 2'b10, 3'b100, 2'd0, 1'b0},
      {4'd3,  3'b010, 2'b10, 3'b010, 2'd0, 1'b1},  // R3 immediate thermal trip
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd0, 1'b0},
      {4'd4,  3'b000, 2'b10, 3'b010, 2'd0, 1'b0},
      {4'd6,  3'b000, 2'b10, 3'b010, 2'd1, 1'b0},  // R6 backoff back at base
      {4'd6,  3'b000, 2'b10, 3'b010, 2'd1, 1'b0},
      {4'd6,  3'b000, 2'b10, 3'b100, 2'd1, 1'b0},  // R6 base wait of 2
      {4'd11, 3'b000, 2'b10, 3'b100, 2'd1, 1'b0},
      {4'd11, 3'b000, 2'b10, 3'b100, 2'd1, 1'b0},  // R11 good edge 1
      {4'd11, 3'b000, 2'b10, 3'b100, 2'd1, 1'b0},
      {4'd11, 3'b000, 2'b10, 3'b100, 2'd1, 1'b0},
      {4'd11, 3'b000, 2'b10, 3'b100, 2'd0, 1'b0},  // R11 fourth good edge clears
      {4'd2,  3'b100, 2'b10, 3'b100, 2'd0, 1'b0},  // R2 short spike
      {4'd2,  3'b000, 2'b10, 3'b100, 2'd0, 1'b0},  // R2 returns without trip
      {4'd2,  3'b000, 2'b10, 3'b100, 2'd0, 1'b0},
      {4'd8,  3'b100, 2'b00, 3'b100, 2'd0, 1'b0},  // R8 latch-off mode
      {4'd8,  3'b100, 2'b00, 3'b100, 2'd0, 1'b0},
      {4'd10, 3'b100, 2'b00, 3'b010, 2'd0, 1'b1},
      {4'd8,  3'b000, 2'b00, 3'b011, 2'd0, 1'b1},  // R8 direct latch, R10 logged
      {4'd8,  3'b000, 2'b00, 3'b011, 2'd0, 1'b0},
      {4'd7,  3'b001, 2'b00, 3'b100, 2'd0, 1'b0},  // R7 clear
      {4'd7,  3'b000, 2'b00, 3'b100, 2'd0, 1'b0}
   };

   task automatic chk(input int req, input logic [5:0] act, input logic [5:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      #100000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int logs;
      bit saw_latch;
      bit saw_gate;
      repeat (3) @(negedge clk);
      // R1 reset values {gate,fault,latched,cnt,log}
      chk(1, {gate, fault, latched, cnt, logp}, 6'b100_00_0, "reset state");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(1, {gate, fault, latched, cnt, logp}, 6'b100_00_0, "idle after reset");

      for (int i = 0; i < NROW; i++) begin
         {oc, ot, clr} = TBL[i][10:8];
         mode          = TBL[i][7:6];
         @(posedge clk);
         @(negedge clk);
         chk(int'(TBL[i][14:11]), {gate, fault, latched, cnt, logp}, TBL[i][5:0],
             $sformatf("row %0d", i));
      end

      // R9 hiccup: continuous overcurrent never latches
      {oc, ot, clr} = 3'b100;
      mode = 2'b01;
      logs = 0;
      saw_latch = 1'b0;
      saw_gate = 1'b0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (logp) logs++;
         if (latched) saw_latch = 1'b1;
         if (gate && k > 20) saw_gate = 1'b1;
      end
      chk(9, {5'd0, saw_latch}, 6'd0, "hiccup latched");
      chk(9, {5'd0, saw_gate}, 6'd1, "hiccup keeps restarting");
      chk(9, {4'd0, cnt}, 6'd3, "hiccup count saturates");
      chk(10, {5'd0, (logs >= 6)}, 6'd1, "hiccup trips logged");

      // R7 clear in hiccup outside latch has no effect on state
      clr = 1'b1;
      oc = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(7, {5'd0, latched}, 6'd0, "clear outside latch");
      clr = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule